// File: doc/BRIEF.md
# Multi-Mode Capture/Compare/PWM Timer

This block is a timer peripheral with a single counter that serves one of three jobs at a time. It can run as a plain periodic timer, timestamp edges on an external input, or drive a compare/PWM pin from two compare values. Software uses a small register port to choose the job, select a counter width of one half-word or two half-words, and load the period and the two compare values. It also reads captured timestamps and clears event flags through the same port.

The counter advances on each clock where the count-enable input `tick_i` is high. It returns to zero after it equals the period. That rollover sets a sticky timer flag and produces a one-cycle trigger pulse for an ADC. Compare matches and accepted captures set a second sticky flag. A capture that arrives while the previous timestamp is still unread keeps the old value and raises an overflow status bit.

The register port decodes six word addresses:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 enable, bit 1 wide counter, bits 7:4 mode |
| 1 | Period |
| 2 | First compare value |
| 3 | Second compare value |
| 4 | Capture buffer, read-only; reading it consumes the timestamp |
| 5 | Status: bit 0 timer flag, bit 1 event flag, bit 2 overflow, bit 3 buffer full; writing 1 to bits 0 to 2 clears them |

Top module: `modal_timebase_unit`

## Requirements
- R1: After reset, every output is low. Every readable register (addresses 0 to 5) reads zero.
- R2: With control bit 1 clear, the counter stays within the low half-word and wraps at the low half of the period. With bit 1 set, it spans the full width and wraps at the full period.
- R3: When the counter equals the period on a tick, it goes to zero on that edge. In the following cycle the timer flag is set and `trig_o` is high for exactly that cycle.
- R4: In mode 1 (single-edge compare), `pwm_o` toggles on the edge after each tick where the counter equals the first compare value, and the event flag is set.
- R5: In mode 2 (dual-edge PWM), `pwm_o` goes high after a match with the first compare value and low after a match with the second. If both match at once, the first wins. The event flag is set on each match with the second value.
- R6: Modes 3, 4 and 5 capture on a rising edge, a falling edge, or either edge of `cap_i`, seen through a SYNC_STAGES-deep synchronizer. The counter value is stored in the buffer, the full bit is set and the event flag is set.
- R7: An edge that arrives while the buffer is full, with no buffer read in the same cycle, sets the overflow bit and leaves the buffer unchanged. A read of address 4 with `rd_en_i` clears the full bit.
- R8: The timer, event and overflow flags stay set until cleared by writing 1 to the matching status bit (0, 1, 2). A new set in the same cycle as the clear wins.
- R9: While enable is set, writes to the mode and width fields are ignored. Clearing enable forces the counter and `pwm_o` to zero.
- R10: Written compare values take effect only at a counter rollover or while the block is disabled.
- R11: Mode codes 6 to 15 leave the counter stopped, and no rollover, compare or capture event occurs.
- R12: The counter changes only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable |
| cap_i | input | 1 | Asynchronous capture input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 2*TW | Register write data |
| rd_en_i | input | 1 | Read strobe; consumes the capture buffer when the address is 4 |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 2*TW | Read data, combinational from the address |
| pwm_o | output | 1 | Compare/PWM pin |
| tmr_flag_o | output | 1 | Sticky timer (rollover) flag |
| evt_flag_o | output | 1 | Sticky capture/compare event flag |
| trig_o | output | 1 | One-cycle ADC trigger on rollover |

## Verification
The bench builds the block with TW = 8 and SYNC_STAGES = 2, with the wide option allowed. With these values a narrow counter wraps at 255 and a wide one reaches 300 within a few hundred cycles, so both width variants and the period masking are exercised fully. The two-stage synchronizer keeps capture latency short. This lets back-to-back edges, overflow and read-versus-capture ordering all occur within a few cycles of one another.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
   localparam logic [ADDR_W-1:0] A_CMP_A  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMP_B  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAPBUF = 3'd4;
   localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

   localparam logic [3:0] M_TIMER    = 4'd0;
   localparam logic [3:0] M_CMP_ONE  = 4'd1;
   localparam logic [3:0] M_CMP_TWO  = 4'd2;
   localparam logic [3:0] M_CAP_RISE = 4'd3;
   localparam logic [3:0] M_CAP_FALL = 4'd4;
   localparam logic [3:0] M_CAP_BOTH = 4'd5;

   localparam int NFLAG  = 3;
   localparam int F_TMR  = 0;
   localparam int F_EVT  = 1;
   localparam int F_OVF  = 2;

   function automatic logic mode_runs(input logic [3:0] m);
      return m <= M_CAP_BOTH;
   endfunction
endpackage

// File: rtl/mtu_timebase.sv
module mtu_timebase #(
   parameter int TW = 16
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic            wide_i,
   input  logic [2*TW-1:0] period_i,
   output logic [2*TW-1:0] count_o,
   output logic [2*TW-1:0] mask_o,
   output logic            wrap_o
);
   localparam int CW = 2*TW;

   logic [CW-1:0] per_eff;
   logic [CW-1:0] nxt;

   always_comb begin
      mask_o  = wide_i ? {CW{1'b1}} : {{TW{1'b0}}, {TW{1'b1}}};
      per_eff = period_i & mask_o;
      nxt     = (count_o + 1'b1) & mask_o;
   end

   assign wrap_o = run_i && tick_i && (count_o == per_eff);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              count_o <= '0;
      else if (!en_i)           count_o <= '0;
      else if (run_i && tick_i) count_o <= wrap_o ? '0 : nxt;
   end
endmodule

// File: rtl/mtu_compare.sv
module mtu_compare
   import mtu_pkg::*;
#(
   parameter int TW = 16
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic            wrap_i,
   input  logic [3:0]      mode_i,
   input  logic [2*TW-1:0] mask_i,
   input  logic [2*TW-1:0] count_i,
   input  logic [2*TW-1:0] ra_i,
   input  logic [2*TW-1:0] rb_i,
   output logic            pwm_o,
   output logic            evt_o
);
   localparam int CW = 2*TW;

   logic [CW-1:0] ra_act, rb_act;
   logic          hit_a, hit_b;

   // shadow copies refresh only at rollover or while disabled
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ra_act <= '0;
         rb_act <= '0;
      end else if (!en_i || wrap_i) begin
         ra_act <= ra_i;
         rb_act <= rb_i;
      end
   end

   assign hit_a = run_i && tick_i && (count_i == (ra_act & mask_i));
   assign hit_b = run_i && tick_i && (count_i == (rb_act & mask_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pwm_o <= 1'b0;
      else if (!en_i)    pwm_o <= 1'b0;
      else begin
         unique case (mode_i)
            M_CMP_ONE: if (hit_a) pwm_o <= ~pwm_o;
            M_CMP_TWO: begin
               if (hit_a)      pwm_o <= 1'b1;
               else if (hit_b) pwm_o <= 1'b0;
            end
            default:   pwm_o <= 1'b0;
         endcase
      end
   end

   assign evt_o = ((mode_i == M_CMP_ONE) && hit_a) ||
                  ((mode_i == M_CMP_TWO) && hit_b);
endmodule

// File: rtl/mtu_capture.sv
module mtu_capture
   import mtu_pkg::*;
#(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic [3:0]      mode_i,
   input  logic            cap_i,
   input  logic            take_i,
   input  logic [2*TW-1:0] count_i,
   output logic [2*TW-1:0] buf_o,
   output logic            full_o,
   output logic            evt_o,
   output logic            ovf_o
);
   logic [SYNC_STAGES-1:0] sr;
   logic                   prev;
   logic                   rise, fall, edge_ok, accept;

   if (SYNC_STAGES == 2) begin : g_sync2
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sr <= '0;
         else         sr <= {sr[0], cap_i};
      end
   end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sr <= '0;
         else         sr <= {sr[SYNC_STAGES-2:0], cap_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev <= 1'b0;
      else         prev <= sr[SYNC_STAGES-1];
   end

   assign rise    =  sr[SYNC_STAGES-1] & ~prev;
   assign fall    = ~sr[SYNC_STAGES-1] &  prev;
   assign edge_ok = en_i && (((mode_i == M_CAP_RISE) && rise) ||
                             ((mode_i == M_CAP_FALL) && fall) ||
                             ((mode_i == M_CAP_BOTH) && (rise || fall)));
   assign accept  = edge_ok && (!full_o || take_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_o  <= '0;
         full_o <= 1'b0;
      end else begin
         if (accept) buf_o <= count_i;
         if (accept)      full_o <= 1'b1;
         else if (take_i) full_o <= 1'b0;
      end
   end

   assign evt_o = accept;
   assign ovf_o = edge_ok && full_o && !take_i;
endmodule

// File: rtl/modal_timebase_unit.sv
module modal_timebase_unit
   import mtu_pkg::*;
#(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ALLOW_WIDE  = 1'b1
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              cap_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [2*TW-1:0]   wr_data_i,
   input  logic              rd_en_i,
   input  logic [2:0]        rd_addr_i,
   output logic [2*TW-1:0]   rd_data_o,
   output logic              pwm_o,
   output logic              tmr_flag_o,
   output logic              evt_flag_o,
   output logic              trig_o
);
   localparam int CW = 2*TW;

   if (TW < 4 || TW > 32) begin : g_bad_tw
      $error("modal_timebase_unit: TW must lie in 4..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modal_timebase_unit: SYNC_STAGES must be at least 2");
   end

   logic          en_q, wide_q;
   logic [3:0]    mode_q;
   logic [CW-1:0] per_q, ra_q, rb_q;
   logic [CW-1:0] count, mask, cap_buf;
   logic          run, wrap, cmp_evt, cap_evt, cap_ovf, cap_full, cap_take;
   logic          wr_ctrl, wr_stat;
   logic [NFLAG-1:0] flag_set, flag_q;

   assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
   assign wr_stat  = wr_en_i && (wr_addr_i == A_STATUS);
   assign cap_take = rd_en_i && (rd_addr_i == A_CAPBUF);
   assign run      = en_q && mode_runs(mode_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         mode_q <= M_TIMER;
         per_q  <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
      end else if (wr_en_i) begin
         unique case (wr_addr_i)
            A_CTRL: begin
               en_q <= wr_data_i[0];
               if (!en_q) mode_q <= wr_data_i[7:4];
            end
            A_PERIOD: per_q <= wr_data_i;
            A_CMP_A:  ra_q  <= wr_data_i;
            A_CMP_B:  rb_q  <= wr_data_i;
            default:  ;
         endcase
      end
   end

   if (ALLOW_WIDE) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)               wide_q <= 1'b0;
         else if (wr_ctrl && !en_q) wide_q <= wr_data_i[1];
      end
   end else begin : g_narrow
      assign wide_q = 1'b0;
   end

   mtu_timebase #(.TW(TW)) u_tb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q),
      .run_i    (run),
      .tick_i   (tick_i),
      .wide_i   (wide_q),
      .period_i (per_q),
      .count_o  (count),
      .mask_o   (mask),
      .wrap_o   (wrap)
   );

   mtu_compare #(.TW(TW)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q),
      .run_i   (run),
      .tick_i  (tick_i),
      .wrap_i  (wrap),
      .mode_i  (mode_q),
      .mask_i  (mask),
      .count_i (count),
      .ra_i    (ra_q),
      .rb_i    (rb_q),
      .pwm_o   (pwm_o),
      .evt_o   (cmp_evt)
   );

   mtu_capture #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q),
      .mode_i  (mode_q),
      .cap_i   (cap_i),
      .take_i  (cap_take),
      .count_i (count),
      .buf_o   (cap_buf),
      .full_o  (cap_full),
      .evt_o   (cap_evt),
      .ovf_o   (cap_ovf)
   );

   assign flag_set[F_TMR] = wrap;
   assign flag_set[F_EVT] = cmp_evt | cap_evt;
   assign flag_set[F_OVF] = cap_ovf;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
         trig_o <= 1'b0;
      end else begin
         trig_o <= wrap;
         for (int i = 0; i < NFLAG; i++) begin
            if (flag_set[i])                   flag_q[i] <= 1'b1;
            else if (wr_stat && wr_data_i[i])  flag_q[i] <= 1'b0;
         end
      end
   end

   assign tmr_flag_o = flag_q[F_TMR];
   assign evt_flag_o = flag_q[F_EVT];

   always_comb begin
      unique case (rd_addr_i)
         A_CTRL:   rd_data_o = {{(CW-8){1'b0}}, mode_q, 2'b00, wide_q, en_q};
         A_PERIOD: rd_data_o = per_q;
         A_CMP_A:  rd_data_o = ra_q;
         A_CMP_B:  rd_data_o = rb_q;
         A_CAPBUF: rd_data_o = cap_buf;
         A_STATUS: rd_data_o = {{(CW-4){1'b0}}, cap_full, flag_q};
         default:  rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
   parameter int TW = 16
)(
   input logic            clk_i,
   input logic            rst_ni,
   input logic            en_i,
   input logic            wide_i,
   input logic [3:0]      mode_i,
   input logic [2*TW-1:0] count_i,
   input logic            pwm_i,
   input logic            trig_i,
   input logic            tmr_i,
   input logic            full_i,
   input logic [2*TW-1:0] buf_i,
   input logic            take_i
);
   AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (count_i == '0 && !pwm_i));                                  // R9
   AST_MODE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i)) |-> ($stable(mode_i) && $stable(wide_i)));       // R9
   AST_NARROW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wide_i |-> (count_i[2*TW-1:TW] == '0));                               // R2
   AST_TRIG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_i |-> tmr_i);                                                     // R3
   AST_CAP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_i && !take_i) |=> $stable(buf_i));                               // R7
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && mode_i > 4'd5) |=> !trig_i);                                  // R11
endmodule

bind modal_timebase_unit mtu_checker #(.TW(TW)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .en_i    (en_q),
   .wide_i  (wide_q),
   .mode_i  (mode_q),
   .count_i (count),
   .pwm_i   (pwm_o),
   .trig_i  (trig_o),
   .tmr_i   (tmr_flag_o),
   .full_i  (cap_full),
   .buf_i   (cap_buf),
   .take_i  (cap_take)
);

// File: tb/sim_modal_timebase_unit.sv
module sim_modal_timebase_unit;
   localparam int TW = 8;
   localparam int CW = 2*TW;
   localparam int S  = 2;

   logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cap = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]    wr_addr = '0, rd_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data;
   logic          pwm, tmr, evt, trig;
   bit            done = 1'b0;
   int            n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   modal_timebase_unit #(.TW(TW), .SYNC_STAGES(S), .ALLOW_WIDE(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_i(cap),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .pwm_o(pwm), .tmr_flag_o(tmr), .evt_flag_o(evt), .trig_o(trig)
   );

   // behavioural reference model
   logic [CW-1:0] m_cnt, m_per, m_rap, m_rbp, m_ra, m_rb, m_buf;
   logic [3:0]    m_mode;
   logic          m_en, m_wide, m_pwm, m_tmr, m_evt, m_ovf, m_full, m_trig;
   bit            hist[$];

   always @(posedge clk) begin : model
      logic [CW-1:0] msk;
      logic run, wrap, ha, hb, take, rise, fall, edg, acc, ovs, cev, clr;
      if (!rst_n) begin
         m_cnt = '0; m_per = '0; m_rap = '0; m_rbp = '0; m_ra = '0; m_rb = '0; m_buf = '0;
         m_mode = '0; m_en = 0; m_wide = 0; m_pwm = 0; m_tmr = 0; m_evt = 0;
         m_ovf = 0; m_full = 0; m_trig = 0;
         hist.delete();
         repeat (S+1) hist.push_back(1'b0);
      end else begin
         msk  = m_wide ? {CW{1'b1}} : {{TW{1'b0}}, {TW{1'b1}}};
         run  = m_en && (m_mode <= 4'd5);
         wrap = run && tick && (m_cnt == (m_per & msk));
         ha   = run && tick && (m_cnt == (m_ra & msk));
         hb   = run && tick && (m_cnt == (m_rb & msk));
         take = rd_en && (rd_addr == 3'd4);
         rise = hist[S-1] && !hist[S];
         fall = !hist[S-1] && hist[S];
         edg  = m_en && ((m_mode == 4'd3 && rise) || (m_mode == 4'd4 && fall) ||
                         (m_mode == 4'd5 && (rise || fall)));
         acc  = edg && (!m_full || take);
         ovs  = edg && m_full && !take;
         cev  = (m_mode == 4'd1 && ha) || (m_mode == 4'd2 && hb);
         clr  = wr_en && (wr_addr == 3'd5);
         if (acc) m_buf = m_cnt;
         m_full = acc ? 1'b1 : (take ? 1'b0 : m_full);
         m_tmr  = wrap ? 1'b1 : ((clr && wr_data[0]) ? 1'b0 : m_tmr);
         m_evt  = (cev || acc) ? 1'b1 : ((clr && wr_data[1]) ? 1'b0 : m_evt);
         m_ovf  = ovs ? 1'b1 : ((clr && wr_data[2]) ? 1'b0 : m_ovf);
         m_trig = wrap;
         if (!m_en) m_pwm = 1'b0;
         else if (m_mode == 4'd1) begin if (ha) m_pwm = !m_pwm; end
         else if (m_mode == 4'd2) begin
            if (ha) m_pwm = 1'b1; else if (hb) m_pwm = 1'b0;
         end else m_pwm = 1'b0;
         if (!m_en) m_cnt = '0;
         else if (run && tick) m_cnt = wrap ? '0 : ((m_cnt + 1'b1) & msk);
         if (!m_en || wrap) begin m_ra = m_rap; m_rb = m_rbp; end
         hist.push_front(cap);
         while (hist.size() > S+1) void'(hist.pop_back());
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  if (!m_en) begin m_mode = wr_data[7:4]; m_wide = wr_data[1]; end
                  m_en = wr_data[0];
               end
               3'd1: m_per = wr_data;
               3'd2: m_rap = wr_data;
               3'd3: m_rbp = wr_data;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [CW-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {{(CW-8){1'b0}}, m_mode, 2'b00, m_wide, m_en};
         3'd1: return m_per;
         3'd2: return m_rap;
         3'd3: return m_rbp;
         3'd4: return m_buf;
         3'd5: return {{(CW-4){1'b0}}, m_full, m_ovf, m_evt, m_tmr};
         default: return '0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [2:0] a);
      case (a)
         3'd0: return "R9";
         3'd4: return "R6";
         3'd5: return "R7 R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [CW-1:0] got, input logic [CW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, got, exp);
      end
   endtask

   // compare on every clock, at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(m_mode == 4'd1 ? "R4" : "R5", "pwm_o", CW'(pwm), CW'(m_pwm));
         check("R3", "trig_o", CW'(trig), CW'(m_trig));
         check("R3", "tmr_flag_o", CW'(tmr), CW'(m_tmr));
         check("R8", "evt_flag_o", CW'(evt), CW'(m_evt));
         check(rd_tag(rd_addr), "rd_data_o", rd_data, m_read(rd_addr));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc(1);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a);
      rd_addr = a; rd_en = 1'b1;
      cyc(1);
      rd_en = 1'b0;
   endtask

   task automatic pulse_cap(input int hi, input int lo);
      cap = 1'b1; cyc(hi);
      cap = 1'b0; cyc(lo);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset values on every output and register
      for (int a = 0; a < 6; a++) begin
         rd_addr = 3'(a);
         #2;
         check("R1", "reset rd_data_o", rd_data, '0);
         check("R1", "reset outputs", CW'({pwm, tmr, evt, trig}), '0);
         cyc(1);
      end
      tick = 1'b1;

      // R3: plain timer, period 5, narrow
      wr(3'd1, 16'd5); wr(3'd0, 16'h0001); cyc(20);
      // R8: flags sticky then cleared by writing ones
      rd(3'd5); cyc(3); wr(3'd5, 16'h0007); rd(3'd5);

      // R12: sparse ticks
      for (int i = 0; i < 30; i++) begin
         tick = (i % 3 == 0);
         cyc(1);
      end
      tick = 1'b1;

      // R9: mode and width writes ignored while enabled
      wr(3'd0, 16'h0023); rd(3'd0); cyc(3);
      wr(3'd0, 16'h0000); cyc(2); rd(3'd0);

      // R2: narrow counter masks the period high half, wraps at 255
      wr(3'd1, 16'h01FF); wr(3'd0, 16'h0001); cyc(300); wr(3'd0, 16'h0000);
      // R2: wide counter runs past 255 up to 300
      wr(3'd1, 16'h012C); wr(3'd0, 16'h0003); cyc(620); wr(3'd0, 16'h0000);

      // R4: single-edge compare toggles on first compare value
      wr(3'd1, 16'd9); wr(3'd2, 16'd3); wr(3'd0, 16'h0011); cyc(40);
      wr(3'd0, 16'h0000); wr(3'd5, 16'h0007);

      // R5: dual-edge PWM
      wr(3'd2, 16'd2); wr(3'd3, 16'd6); wr(3'd0, 16'h0021); cyc(25);
      // R10: new compare values mid-period wait for rollover
      wr(3'd2, 16'd7); cyc(3); wr(3'd3, 16'd8); cyc(25);
      // R5: equal values, first wins
      wr(3'd3, 16'd7); cyc(25);
      // second value below first
      wr(3'd2, 16'd8); wr(3'd3, 16'd1); cyc(25);
      wr(3'd0, 16'h0000); wr(3'd5, 16'h0007); cyc(2);

      // R6: capture modes rise, fall, both
      for (int m = 3; m <= 5; m++) begin
         wr(3'd0, CW'((m << 4) | 1)); cyc(7);
         pulse_cap(5, 6);
         rd(3'd4); rd(3'd5);
         pulse_cap(3, 6);
         rd(3'd4); rd(3'd5);
         wr(3'd0, 16'h0000); wr(3'd5, 16'h0007); cyc(2);
      end

      // R7: overflow keeps first timestamp, read clears full
      wr(3'd1, 16'd40); wr(3'd0, 16'h0051); cyc(4);
      pulse_cap(3, 4); pulse_cap(3, 4);
      rd(3'd5); rd(3'd4); rd(3'd5);
      // read of the buffer in the cycle the capture lands
      cap = 1'b1; cyc(2); rd_addr = 3'd4; rd_en = 1'b1; cyc(1); rd_en = 1'b0; cap = 1'b0;
      cyc(4); rd(3'd5); wr(3'd5, 16'h0007); rd(3'd5);
      wr(3'd0, 16'h0000); cyc(2);

      // R11: idle mode code 9
      wr(3'd0, 16'h0091); cyc(20); pulse_cap(3, 4); rd(3'd5);
      wr(3'd0, 16'h0000); cyc(3);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule